// File: doc/BRIEF.md
# Synchronous Slave Serial Receiver

This block is the receive side of a serial port that works in synchronous slave mode. An external master supplies both the shift clock and the data line. The block brings both lines into the system clock domain and finds the active clock edge. It shifts the data in least significant bit first. Each finished word is copied into a holding register, which software reads through a simple read strobe.

A finished word raises a receive-complete flag. When the receive interrupt is enabled, it also raises an interrupt request, and while the core sits in a low-power state it raises a wake request. A nine-bit word format can be selected; the extra bit is then shown on a separate status output next to the eight data bits. If a word finishes while the previous one is still unread, the block sets an overrun error, drops the new word and stops receiving. Turning off the continuous-receive enable clears the error.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, rx_data_o, rx_bit9_o, rx_done_o, overrun_o, irq_o and wake_o are all 0.
- R2: Bits are received only while port_en_i=1, sync_mode_i=1, clk_src_i=0 and cont_rx_en_i=1. If any of these conditions fails, clock edges are ignored: a full word clocked in then leaves rx_done_o at 0.
- R3: single_rx_en_i has no effect on reception. Received words, flags and errors are the same whatever its value.
- R4: With clk_pol_i=0, data is sampled on rising edges of ser_clk_i. With clk_pol_i=1, it is sampled on falling edges. The first bit sampled is the least significant bit of the word.
- R5: With nine_bit_i=0, the 8th sampled bit completes a word. Its bits appear on rx_data_o, rx_bit9_o reads 0, and rx_done_o is set. rx_data_o changes only in a cycle where rx_done_o is 1.
- R6: With nine_bit_i=1, the 9th sampled bit completes a word. The first eight bits appear on rx_data_o and the ninth appears on rx_bit9_o.
- R7: A one-cycle pulse on rd_data_i clears rx_done_o, and rx_data_o/rx_bit9_o keep their value. rx_done_o falls only after such a pulse. rx_bit9_o belongs to the word held, so it is read before rd_data_i is pulsed.
- R8: If a word completes while rx_done_o=1 and no read is pulsed in that cycle, overrun_o is set, the holding register keeps the old word, and no further words are received while overrun_o=1.
- R9: cont_rx_en_i=0 clears overrun_o on the next cycle and drops any partly received word. Reception restarts from bit 0 once the enable returns.
- R10: irq_o is 1 exactly when rx_done_o=1 and rx_ie_i=1.
- R11: wake_o is 1 exactly when irq_o=1 and low_power_i=1. Reception continues unchanged while low_power_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Shift clock from external master (asynchronous) |
| ser_dat_i | input | 1 | Serial data from external master (asynchronous) |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select |
| clk_src_i | input | 1 | Clock source: 0 = external (slave) |
| single_rx_en_i | input | 1 | Single-receive enable, ignored in slave mode |
| cont_rx_en_i | input | 1 | Continuous-receive enable; low clears errors |
| nine_bit_i | input | 1 | 1 = nine-bit words |
| clk_pol_i | input | 1 | 0 = rising edge active, 1 = falling edge active |
| rx_ie_i | input | 1 | Receive interrupt enable |
| low_power_i | input | 1 | Core is in a low-power state |
| rd_data_i | input | 1 | Read strobe for the holding register |
| rx_data_o | output | 8 | Held data byte |
| rx_bit9_o | output | 1 | Held ninth bit |
| rx_done_o | output | 1 | Receive-complete flag |
| overrun_o | output | 1 | Overrun error |
| irq_o | output | 1 | Receive interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Every byte value is sent in eight-bit mode on rising edges, and every nine-bit value is sent on falling edges. These two sweeps show whether the bit order is right, whether every bit position is mapped where it belongs, and whether each polarity picks the edge it should. During the byte sweep the ignored single-receive enable follows the data, so any effect it has shows up as a wrong word. Full words are also sent with each qualifying control turned off in turn, which separates a missing condition from edge handling. Directed sequences cover a second and third word arriving unread, a partial word cut off by the enable, and a word received during the low-power state with each interrupt enable setting, to separate the overrun, clear, interrupt and wake paths.

// File: rtl/sync_slave_rx_pkg.sv
// Package: shared width constants and the received-word type.
// Assumes an 8-bit base data width with an optional ninth bit.
package sync_slave_rx_pkg;

    localparam int unsigned RX_DATA_W = 8;
    localparam int unsigned RX_CNT_W  = $clog2(RX_DATA_W + 1);

    typedef struct packed {
        logic                 b9;
        logic [RX_DATA_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/sync_slave_rx_edge.sv
// Synchronizes the external shift clock and data line into the system
// clock domain through STAGES flops each, then flags rising and falling
// edges of the synchronized clock. Data and clock see equal delay.
// Assumes the master holds data stable across several system clocks.
module sync_slave_rx_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    output logic rise_o,
    output logic fall_o,
    output logic dat_o
);

    logic [STAGES-1:0] clk_sr;
    logic [STAGES-1:0] dat_sr;
    logic              clk_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Purpose: first capture flop for both asynchronous lines.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_sr[0] <= 1'b0;
                        dat_sr[0] <= 1'b0;
                    end else begin
                        clk_sr[0] <= ser_clk_i;
                        dat_sr[0] <= ser_dat_i;
                    end
                end
            end else begin : g_next
                // Purpose: further synchronizer stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        clk_sr[g] <= 1'b0;
                        dat_sr[g] <= 1'b0;
                    end else begin
                        clk_sr[g] <= clk_sr[g-1];
                        dat_sr[g] <= dat_sr[g-1];
                    end
                end
            end
        end
    endgenerate

    // Purpose: remember previous synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_last <= 1'b0;
        end else begin
            clk_last <= clk_sr[STAGES-1];
        end
    end

    assign rise_o = clk_sr[STAGES-1] & ~clk_last;
    assign fall_o = ~clk_sr[STAGES-1] & clk_last;
    assign dat_o  = dat_sr[STAGES-1];

endmodule

// File: rtl/sync_slave_rx_shift.sv
// Receive shift register with bit counter. Shifts LSB first on each bit
// strobe while run_i is high; emits a one-cycle word strobe with the
// assembled word when the last bit (8th or 9th) arrives. Dropping run_i
// discards any partial word. Assumes bit strobes are single-cycle.
module sync_slave_rx_shift
    import sync_slave_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_i,
    input  logic     bit_stb_i,
    input  logic     din_i,
    input  logic     nine_i,
    output logic     word_stb_o,
    output rx_word_t word_o
);

    logic [RX_DATA_W:0]  sr;
    logic [RX_DATA_W:0]  sr_nxt;
    logic [RX_CNT_W-1:0] cnt;
    logic                last;

    // Purpose: next shift value and last-bit decode for the chosen length.
    always_comb begin
        sr_nxt = {din_i, sr[RX_DATA_W:1]};
        if (nine_i) begin
            last = (cnt == RX_CNT_W'(RX_DATA_W));
        end else begin
            last = (cnt == RX_CNT_W'(RX_DATA_W - 1));
        end
    end

    // Purpose: align the assembled word according to its length.
    always_comb begin
        if (nine_i) begin
            word_o.b9   = sr_nxt[RX_DATA_W];
            word_o.data = sr_nxt[RX_DATA_W-1:0];
        end else begin
            word_o.b9   = 1'b0;
            word_o.data = sr_nxt[RX_DATA_W:1];
        end
    end

    assign word_stb_o = run_i & bit_stb_i & last;

    // Purpose: shift and count bits; clear the count when not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (bit_stb_i) begin
            sr  <= sr_nxt;
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sync_slave_rx_hold.sv
// Holding register, receive-complete flag and overrun error. A word
// strobe loads the register when it is empty or read in the same cycle;
// otherwise the word is dropped and overrun is set. Overrun clears only
// through clr_err_i. Assumes rd_i is a single-cycle pulse.
module sync_slave_rx_hold
    import sync_slave_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     word_stb_i,
    input  rx_word_t word_i,
    input  logic     rd_i,
    input  logic     clr_err_i,
    output rx_word_t word_o,
    output logic     done_o,
    output logic     ovr_o
);

    logic accept;

    assign accept = word_stb_i & (~done_o | rd_i);

    // Purpose: load the holding register and track the complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            done_o <= 1'b0;
        end else if (accept) begin
            word_o <= word_i;
            done_o <= 1'b1;
        end else if (rd_i) begin
            done_o <= 1'b0;
        end
    end

    // Purpose: set overrun on an unread collision, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_o <= 1'b0;
        end else if (clr_err_i) begin
            ovr_o <= 1'b0;
        end else if (word_stb_i && done_o && !rd_i) begin
            ovr_o <= 1'b1;
        end
    end

endmodule

// File: rtl/sync_slave_rx.sv
// Top: synchronous slave serial receiver. Qualifies reception with the
// slave-mode controls, picks the active clock edge by polarity, and
// drives the interrupt and wake requests. The single-receive enable is
// accepted for register compatibility but does not affect reception.
module sync_slave_rx
    import sync_slave_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    input  logic                 port_en_i,
    input  logic                 sync_mode_i,
    input  logic                 clk_src_i,
    input  logic                 single_rx_en_i,
    input  logic                 cont_rx_en_i,
    input  logic                 nine_bit_i,
    input  logic                 clk_pol_i,
    input  logic                 rx_ie_i,
    input  logic                 low_power_i,
    input  logic                 rd_data_i,
    output logic [RX_DATA_W-1:0] rx_data_o,
    output logic                 rx_bit9_o,
    output logic                 rx_done_o,
    output logic                 overrun_o,
    output logic                 irq_o,
    output logic                 wake_o
);

    logic     rise, fall, dat_s;
    logic     bit_stb, run, slave_on;
    logic     word_stb;
    rx_word_t word_new, word_held;
    logic     unused_single_rx;

    assign unused_single_rx = single_rx_en_i;

    sync_slave_rx_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .rise_o    (rise),
        .fall_o    (fall),
        .dat_o     (dat_s)
    );

    // Purpose: reception qualifier and active-edge selection.
    always_comb begin
        slave_on = port_en_i & sync_mode_i & ~clk_src_i & cont_rx_en_i;
        run      = slave_on & ~overrun_o;
        bit_stb  = clk_pol_i ? fall : rise;
    end

    sync_slave_rx_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .bit_stb_i  (bit_stb),
        .din_i      (dat_s),
        .nine_i     (nine_bit_i),
        .word_stb_o (word_stb),
        .word_o     (word_new)
    );

    sync_slave_rx_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_stb_i (word_stb),
        .word_i     (word_new),
        .rd_i       (rd_data_i),
        .clr_err_i  (~cont_rx_en_i),
        .word_o     (word_held),
        .done_o     (rx_done_o),
        .ovr_o      (overrun_o)
    );

    assign rx_data_o = word_held.data;
    assign rx_bit9_o = word_held.b9;
    assign irq_o     = rx_done_o & rx_ie_i;
    assign wake_o    = irq_o & low_power_i;

endmodule

// File: rtl/sync_slave_rx_chk.sv
// Checker: temporal properties of the receiver, bound to the top module.
module sync_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cont_rx_en_i,
    input logic       rd_data_i,
    input logic [7:0] rx_data_o,
    input logic       rx_done_o,
    input logic       overrun_o,
    input logic       irq_o,
    input logic       wake_o
);

    AST_DATA_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data_o) |-> rx_done_o); // R5

    AST_DONE_FALLS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done_o) |-> $past(rd_data_i)); // R7

    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(rx_done_o)); // R8

    AST_OVR_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && $past(overrun_o)) |-> $stable(rx_data_o)); // R8

    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_rx_en_i |=> !overrun_o); // R9

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rx_done_o); // R10

    AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> irq_o); // R11

endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cont_rx_en_i (cont_rx_en_i),
    .rd_data_i    (rd_data_i),
    .rx_data_o    (rx_data_o),
    .rx_done_o    (rx_done_o),
    .overrun_o    (overrun_o),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
);

// File: tb/sync_slave_rx_bench.sv
module sync_slave_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk_i = 1'b0, ser_dat_i = 1'b0;
    logic       port_en_i = 1'b0, sync_mode_i = 1'b0, clk_src_i = 1'b0;
    logic       single_rx_en_i = 1'b0, cont_rx_en_i = 1'b0;
    logic       nine_bit_i = 1'b0, clk_pol_i = 1'b0, rx_ie_i = 1'b0;
    logic       low_power_i = 1'b0, rd_data_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_bit9_o, rx_done_o, overrun_o, irq_o, wake_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sync_slave_rx u_sync_slave_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
        .port_en_i(port_en_i), .sync_mode_i(sync_mode_i), .clk_src_i(clk_src_i),
        .single_rx_en_i(single_rx_en_i), .cont_rx_en_i(cont_rx_en_i),
        .nine_bit_i(nine_bit_i), .clk_pol_i(clk_pol_i), .rx_ie_i(rx_ie_i),
        .low_power_i(low_power_i), .rd_data_i(rd_data_i),
        .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o), .rx_done_o(rx_done_o),
        .overrun_o(overrun_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sends n bits LSB first; each active edge follows stable data.
    task automatic send_bits(input logic [8:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_dat_i = v[i];
            repeat (4) @(negedge clk);
            ser_clk_i = ~ser_clk_i;
            repeat (4) @(negedge clk);
            ser_clk_i = ~ser_clk_i;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic read_pulse();
        @(negedge clk);
        rd_data_i = 1'b1;
        @(negedge clk);
        rd_data_i = 1'b0;
    endtask

    // Reconfigures with reception off so the idle clock level can change.
    task automatic set_mode(input logic pol, input logic nine);
        @(negedge clk);
        cont_rx_en_i = 1'b0;
        clk_pol_i = pol;
        nine_bit_i = nine;
        ser_clk_i = pol;
        repeat (8) @(negedge clk);
        cont_rx_en_i = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data_o, 0);
        chk("R1 bit9", rx_bit9_o, 0);
        chk("R1 done", rx_done_o, 0);
        chk("R1 ovr", overrun_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 wake", wake_o, 0);

        port_en_i = 1'b1;
        sync_mode_i = 1'b1;
        clk_src_i = 1'b0;

        // R4 R5 R3 R7: all bytes, rising edge, single-receive enable toggling
        set_mode(1'b0, 1'b0);
        for (int v = 0; v < 256; v++) begin
            single_rx_en_i = v[0];
            send_bits(9'(v), 8);
            chk("R5 done", rx_done_o, 1);
            chk("R4 R3 data", rx_data_o, v);
            chk("R5 bit9", rx_bit9_o, 0);
            read_pulse();
            @(negedge clk);
            chk("R7 done cleared", rx_done_o, 0);
            chk("R7 data kept", rx_data_o, v);
        end
        single_rx_en_i = 1'b0;

        // R6 R4: all nine-bit values, falling edge
        set_mode(1'b1, 1'b1);
        for (int v = 0; v < 512; v++) begin
            send_bits(9'(v), 9);
            chk("R6 done", rx_done_o, 1);
            chk("R6 data", rx_data_o, v % 256);
            chk("R6 bit9", rx_bit9_o, v / 256);
            read_pulse();
        end

        // R2: each qualifier off blocks reception
        set_mode(1'b0, 1'b0);
        clk_src_i = 1'b1;
        send_bits(9'h0A5, 8);
        chk("R2 clk_src", rx_done_o, 0);
        clk_src_i = 1'b0;
        set_mode(1'b0, 1'b0);
        sync_mode_i = 1'b0;
        send_bits(9'h05A, 8);
        chk("R2 sync_mode", rx_done_o, 0);
        sync_mode_i = 1'b1;
        set_mode(1'b0, 1'b0);
        port_en_i = 1'b0;
        send_bits(9'h033, 8);
        chk("R2 port_en", rx_done_o, 0);
        port_en_i = 1'b1;
        set_mode(1'b0, 1'b0);
        cont_rx_en_i = 1'b0;
        send_bits(9'h0CC, 8);
        chk("R2 cont", rx_done_o, 0);
        set_mode(1'b0, 1'b0);

        // R10 R11: interrupt and wake, reception during low power
        low_power_i = 1'b1;
        rx_ie_i = 1'b0;
        send_bits(9'h03C, 8);
        chk("R11 rx in low power", rx_data_o, 8'h3C);
        chk("R10 irq off", irq_o, 0);
        chk("R11 wake off", wake_o, 0);
        @(negedge clk);
        rx_ie_i = 1'b1;
        #1;
        chk("R10 irq on", irq_o, 1);
        chk("R11 wake on", wake_o, 1);
        low_power_i = 1'b0;
        #1;
        chk("R11 wake awake", wake_o, 0);
        chk("R10 irq awake", irq_o, 1);
        read_pulse();
        chk("R10 irq after read", irq_o, 0);
        rx_ie_i = 1'b0;

        // R8: overrun keeps old word and blocks further words
        send_bits(9'h011, 8);
        send_bits(9'h022, 8);
        chk("R8 ovr", overrun_o, 1);
        chk("R8 data kept", rx_data_o, 8'h11);
        read_pulse();
        send_bits(9'h044, 8);
        chk("R8 blocked done", rx_done_o, 0);
        chk("R8 blocked data", rx_data_o, 8'h11);

        // R9: clearing by enable, then partial word discarded
        @(negedge clk);
        cont_rx_en_i = 1'b0;
        @(negedge clk);
        chk("R9 ovr cleared", overrun_o, 0);
        cont_rx_en_i = 1'b1;
        send_bits(9'h007, 3);
        @(negedge clk);
        cont_rx_en_i = 1'b0;
        repeat (2) @(negedge clk);
        cont_rx_en_i = 1'b1;
        send_bits(9'h096, 8);
        chk("R9 restart done", rx_done_o, 1);
        chk("R9 restart data", rx_data_o, 8'h96);
        chk("R9 no ovr", overrun_o, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule